// File: doc/BRIEF.md
# Double-Buffered Run Parameter Loader

This unit sits on a shared control bus and holds the runtime parameters of one processing node. Parameter words arrive one per cycle in a fixed order and shift into a staging register that always captures the whole set, whether or not the node reads every entry. A full staged set raises a pending flag. The staged set moves into the active register bank, which feeds the datapath, in one parallel copy.

That copy, called a commit, is allowed only at a run boundary. This means either no run is in progress, or the datapath reports the current run finished in the same cycle. Each commit starts exactly one new run. Staging may continue while a run is executing, so the next set can be loaded during the current run. A newer complete set overwrites an older one that has not yet been committed. A commit also waits while a set is only partly shifted in, so a mixed set is never copied.

Top module: `param_loader`

## Requirements
- R1: Each cycle with `cfg_valid` high accepts one word on `cfg_word`. After a complete set of NUM_PARAMS words is committed, the k-th accepted word of that set (counting from 0) appears on `act_params[k*PARAM_W +: PARAM_W]`.
- R2: The staging register keeps all NUM_PARAMS words of every set. No entry is dropped or merged.
- R3: `param_pending` goes high in the cycle after the last word of a set is accepted. It goes low in the cycle after that set is committed.
- R4: `act_params` changes only as a result of a commit. A commit needs a pending set and no partial set in progress. It also needs either no run active, or `run_done` high in that cycle. The active values therefore stay unchanged for the whole of a run.
- R5: Each commit gives exactly one single-cycle `run_start` pulse, in the cycle after the commit and together with the new `act_params`. `run_busy` is high from that cycle until the cycle after `run_done` is seen, unless a commit in the `run_done` cycle keeps it high and starts the next run straight away.
- R6: If a second complete set is staged before a commit, only the newer set is committed. If a later set is only partly shifted in, the commit waits until that set is complete.
- R7: After reset, `act_params` is zero, `param_pending` and `run_busy` are low, and no `run_start` occurs until the first commit.
- R8: `run_done` has no effect while no run is active. It does not change `act_params` or `run_busy`, and it does not produce `run_start`.
- R9: A word accepted in the same cycle as a commit does not reach the set being committed. It becomes the first word of the next set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | A parameter word is present on `cfg_word` |
| cfg_word | input | PARAM_W | Parameter word from the control bus |
| run_done | input | 1 | The datapath has finished the current run |
| run_start | output | 1 | Single-cycle pulse that starts a run with the new parameters |
| run_busy | output | 1 | A run is in progress |
| param_pending | output | 1 | A complete set is staged and not yet committed |
| act_params | output | NUM_PARAMS*PARAM_W | Active parameters, entry k at bits k*PARAM_W and up |

## Verification
Two pairs of events can land in the same cycle. The first pair is a commit and the arrival of a bus word. The bench provokes it by sending a fifth word directly after a complete set while the unit is idle. It then checks that the started run carries the four earlier words, and that the fifth word begins the set committed on the next `run_done`. The second pair is `run_done` and a commit. The bench stages a full set during a run and ends the run. It then checks that `run_start` pulses, `run_busy` stays high, and the newer set is active with no idle cycle in between.

// File: rtl/ploader_pkg.sv
package ploader_pkg;

    localparam int DEF_NUM_PARAMS = 4;
    localparam int DEF_PARAM_W    = 16;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

endpackage

// File: rtl/pl_stage_shift.sv
module pl_stage_shift #(
    parameter int NUM_PARAMS = ploader_pkg::DEF_NUM_PARAMS,
    parameter int PARAM_W    = ploader_pkg::DEF_PARAM_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          shift_en,
    input  logic [PARAM_W-1:0]            word_in,
    input  logic                          commit,
    output logic [NUM_PARAMS*PARAM_W-1:0] stage_flat,
    output logic                          pending,
    output logic                          aligned
);

    localparam int                CNT_W    = (NUM_PARAMS > 1) ? $clog2(NUM_PARAMS) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(NUM_PARAMS - 1);

    typedef struct packed {
        logic [NUM_PARAMS-1:0][PARAM_W-1:0] slots;
        logic [CNT_W-1:0]                   cnt;
        logic                               pending;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.pending = 1'b0;
        end
        if (shift_en) begin
            for (int k = 0; k < NUM_PARAMS - 1; k++) begin
                st_d.slots[k] = st_q.slots[k+1];
            end
            st_d.slots[NUM_PARAMS-1] = word_in;
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt     = '0;
                st_d.pending = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_flat = st_q.slots;
    assign pending    = st_q.pending;
    assign aligned    = (st_q.cnt == '0);

endmodule

// File: rtl/pl_run_ctrl.sv
module pl_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic aligned,
    input  logic run_done,
    output logic commit,
    output logic run_start,
    output logic run_busy
);

    import ploader_pkg::*;

    typedef struct packed {
        run_state_e state;
        logic       start;
    } ctrl_t;

    ctrl_t ct_d, ct_q;
    logic  boundary;

    always_comb begin
        boundary = (ct_q.state == RUN_IDLE) || run_done;
        commit   = pending && aligned && boundary;
        ct_d       = ct_q;
        ct_d.start = commit;
        if (commit) begin
            ct_d.state = RUN_ACTIVE;
        end else if (ct_q.state == RUN_ACTIVE && run_done) begin
            ct_d.state = RUN_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= '{state: RUN_IDLE, start: 1'b0};
        end else begin
            ct_q <= ct_d;
        end
    end

    assign run_start = ct_q.start;
    assign run_busy  = (ct_q.state == RUN_ACTIVE);

endmodule

// File: rtl/pl_active_bank.sv
module pl_active_bank #(
    parameter int NUM_PARAMS = ploader_pkg::DEF_NUM_PARAMS,
    parameter int PARAM_W    = ploader_pkg::DEF_PARAM_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [NUM_PARAMS*PARAM_W-1:0] src_flat,
    output logic [NUM_PARAMS*PARAM_W-1:0] act_flat
);

    typedef struct packed {
        logic [NUM_PARAMS-1:0][PARAM_W-1:0] regs;
    } bank_t;

    bank_t bk_d, bk_q;

    for (genvar g = 0; g < NUM_PARAMS; g++) begin : g_slot
        always_comb begin
            bk_d.regs[g] = load ? src_flat[g*PARAM_W +: PARAM_W] : bk_q.regs[g];
        end
        assign act_flat[g*PARAM_W +: PARAM_W] = bk_q.regs[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

endmodule

// File: rtl/param_loader.sv
module param_loader #(
    parameter int NUM_PARAMS = ploader_pkg::DEF_NUM_PARAMS,
    parameter int PARAM_W    = ploader_pkg::DEF_PARAM_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_valid,
    input  logic [PARAM_W-1:0]            cfg_word,
    input  logic                          run_done,
    output logic                          run_start,
    output logic                          run_busy,
    output logic                          param_pending,
    output logic [NUM_PARAMS*PARAM_W-1:0] act_params
);

    localparam int SET_W = NUM_PARAMS * PARAM_W;

    logic [SET_W-1:0] stage_flat;
    logic             stage_pending;
    logic             stage_aligned;
    logic             commit;

    pl_stage_shift #(
        .NUM_PARAMS (NUM_PARAMS),
        .PARAM_W    (PARAM_W)
    ) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (cfg_valid),
        .word_in    (cfg_word),
        .commit     (commit),
        .stage_flat (stage_flat),
        .pending    (stage_pending),
        .aligned    (stage_aligned)
    );

    pl_run_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (stage_pending),
        .aligned   (stage_aligned),
        .run_done  (run_done),
        .commit    (commit),
        .run_start (run_start),
        .run_busy  (run_busy)
    );

    pl_active_bank #(
        .NUM_PARAMS (NUM_PARAMS),
        .PARAM_W    (PARAM_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (commit),
        .src_flat (stage_flat),
        .act_flat (act_params)
    );

    assign param_pending = stage_pending;

endmodule

// File: rtl/param_loader_chk.sv
module param_loader_chk #(
    parameter int NUM_PARAMS = ploader_pkg::DEF_NUM_PARAMS,
    parameter int PARAM_W    = ploader_pkg::DEF_PARAM_W
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cfg_valid,
    input logic [PARAM_W-1:0]            cfg_word,
    input logic                          run_done,
    input logic                          run_start,
    input logic                          run_busy,
    input logic                          param_pending,
    input logic [NUM_PARAMS*PARAM_W-1:0] act_params
);

    // R4: active values only move together with a run start
    a_r4_act_only_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_params) |-> run_start);

    // R5: a started run is marked busy
    a_r5_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |-> run_busy);

    // R5: start is a single-cycle pulse unless the run ended while a set was pending
    a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |=> (!run_start || $past(run_done)));

    // R3: a start always follows a pending set
    a_r3_start_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |-> $past(param_pending));

    // R3: pending is cleared by the commit
    a_r3_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        run_start |-> !param_pending);

    // R4: no new run while one is active unless it just finished
    a_r4_no_start_mid_run: assert property (@(posedge clk) disable iff (!rst_n)
        (run_start && $past(run_busy)) |-> $past(run_done));

    // R8: run_done while idle leaves the unit idle
    a_r8_done_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_busy && run_done && !param_pending) |=> (!run_busy && !run_start));

endmodule

bind param_loader param_loader_chk #(
    .NUM_PARAMS (NUM_PARAMS),
    .PARAM_W    (PARAM_W)
) u_chk (.*);

// File: tb/sim_param_loader.sv
module sim_param_loader;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 4;
    localparam int PW         = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_valid = 1'b0;
    logic [PW-1:0]    cfg_word = '0;
    logic             run_done = 1'b0;
    logic             run_start;
    logic             run_busy;
    logic             param_pending;
    logic [NP*PW-1:0] act_params;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [NP*PW-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    param_loader #(.NUM_PARAMS(NP), .PARAM_W(PW)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_valid     (cfg_valid),
        .cfg_word      (cfg_word),
        .run_done      (run_done),
        .run_start     (run_start),
        .run_busy      (run_busy),
        .param_pending (param_pending),
        .act_params    (act_params)
    );

    function automatic logic [NP*PW-1:0] mk(input logic [PW-1:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_word(input logic [PW-1:0] w);
        @(negedge clk);
        cfg_valid = 1'b1;
        cfg_word  = w;
    endtask

    task automatic idle_bus;
        @(negedge clk);
        cfg_valid = 1'b0;
        cfg_word  = '0;
    endtask

    task automatic send_set(input logic [NP*PW-1:0] s);
        for (int k = 0; k < NP; k++) drive_word(s[k*PW +: PW]);
        idle_bus();
    endtask

    task automatic pulse_done;
        @(negedge clk);
        run_done = 1'b1;
        @(negedge clk);
        run_done = 1'b0;
    endtask

    // monitor: every run start must match the next expected committed set (R1, R2, R5)
    always @(negedge clk) begin
        if (rst_n && run_start) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected run_start", 64'(act_params), 64'h0);
            end else begin
                logic [NP*PW-1:0] e;
                e = exp_q.pop_front();
                chk(act_params == e, "R1 committed set", 64'(act_params), 64'(e));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [NP*PW-1:0] sa, sb, sc, sd, se, sf, sg, sh;
        sa = mk(16'h1111, 16'h2222, 16'h3333, 16'h4444);
        sb = mk(16'hB001, 16'hB002, 16'hB003, 16'hB004);
        sc = mk(16'hC0DE, 16'h0000, 16'hFFFF, 16'h8001);
        sd = mk(16'hD001, 16'hD002, 16'hD003, 16'hD004);
        se = mk(16'hE001, 16'hE002, 16'hE003, 16'hE004);
        sf = mk(16'hF001, 16'hF002, 16'hF003, 16'hF004);
        sg = mk(16'h9001, 16'h9002, 16'h9003, 16'h9004);
        sh = mk(16'h7001, 16'h7002, 16'h7003, 16'h7004);

        step(3);
        rst_n = 1'b1;
        step(4);
        // R7: reset state, nothing starts without a commit
        chk(act_params == '0, "R7 act zero", 64'(act_params), 64'h0);
        chk(!run_busy && !param_pending && !run_start, "R7 flags low",
            {61'h0, run_busy, param_pending, run_start}, 64'h0);

        // R1/R3/R5: first set while idle
        exp_q.push_back(sa);
        send_set(sa);
        chk(param_pending == 1'b1, "R3 pending after last word", 64'(param_pending), 64'h1);
        step(1);
        chk(run_start && run_busy, "R5 start and busy", {62'h0, run_start, run_busy}, 64'h3);
        chk(param_pending == 1'b0, "R3 pending cleared", 64'(param_pending), 64'h0);
        step(1);
        chk(run_start == 1'b0, "R5 single pulse", 64'(run_start), 64'h0);
        chk(exp_q.size() == 0, "R1 set A consumed", 64'(exp_q.size()), 64'h0);

        // R4/R6: stage two sets during a run, only the newer one commits
        send_set(sb);
        chk(act_params == sa, "R4 act held in run", 64'(act_params), 64'(sa));
        chk(param_pending == 1'b1, "R3 pending in run", 64'(param_pending), 64'h1);
        exp_q.push_back(sc);
        send_set(sc);
        chk(act_params == sa, "R4 act held after second set", 64'(act_params), 64'(sa));
        pulse_done();
        // commit coincides with run_done: back-to-back run (R5)
        chk(run_start && run_busy, "R5 back-to-back start", {62'h0, run_start, run_busy}, 64'h3);
        chk(act_params == sc, "R6 newer set active", 64'(act_params), 64'(sc));

        // R5: run ends with nothing pending -> idle; partial set does not commit
        drive_word(sd[0 +: PW]);
        drive_word(sd[PW +: PW]);
        idle_bus();
        pulse_done();
        chk(!run_busy && !run_start, "R5 busy falls", {62'h0, run_busy, run_start}, 64'h0);
        chk(act_params == sc, "R2 partial not committed", 64'(act_params), 64'(sc));
        exp_q.push_back(sd);
        drive_word(sd[2*PW +: PW]);
        drive_word(sd[3*PW +: PW]);
        idle_bus();
        step(1);
        chk(act_params == sd && run_busy, "R2 split set committed", 64'(act_params), 64'(sd));

        // R6: pending set plus partial newer set -> commit waits for completion
        send_set(se);
        drive_word(sf[0 +: PW]);
        drive_word(sf[PW +: PW]);
        idle_bus();
        pulse_done();
        chk(!run_busy && !run_start && param_pending, "R6 commit waits on partial",
            {61'h0, run_busy, run_start, param_pending}, 64'h1);
        chk(act_params == sd, "R6 act unchanged while waiting", 64'(act_params), 64'(sd));
        exp_q.push_back(sf);
        drive_word(sf[2*PW +: PW]);
        drive_word(sf[3*PW +: PW]);
        idle_bus();
        step(1);
        chk(act_params == sf, "R6 newer set committed", 64'(act_params), 64'(sf));

        // R8: run_done while idle has no effect
        pulse_done();
        chk(!run_busy, "R5 run finished", 64'(run_busy), 64'h0);
        pulse_done();
        step(1);
        chk(!run_busy && !run_start, "R8 done ignored idle", {62'h0, run_busy, run_start}, 64'h0);
        chk(act_params == sf, "R8 act unchanged", 64'(act_params), 64'(sf));

        // R9: word arriving in commit cycle belongs to the next set
        exp_q.push_back(sh);
        exp_q.push_back(sg);
        for (int k = 0; k < NP; k++) drive_word(sh[k*PW +: PW]);
        drive_word(sg[0 +: PW]);
        idle_bus();
        chk(run_start && act_params == sh, "R9 committed set excludes new word",
            64'(act_params), 64'(sh));
        chk(param_pending == 1'b0, "R9 no pending after one word", 64'(param_pending), 64'h0);
        for (int k = 1; k < NP; k++) drive_word(sg[k*PW +: PW]);
        idle_bus();
        chk(param_pending && act_params == sh, "R9 next set staged", 64'(act_params), 64'(sh));
        pulse_done();
        chk(act_params == sg, "R9 next set committed", 64'(act_params), 64'(sg));
        step(2);
        chk(exp_q.size() == 0, "R5 all starts seen", 64'(exp_q.size()), 64'h0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule